// File: doc/BRIEF.md
# Sequenced Text Command Line Checker

This block sits behind a byte receiver and guards a stream of ASCII command lines. Every line opens with a sequence field (`N` and a decimal number) and closes with a `*` followed by a decimal checksum, then a line-ending byte. While the line arrives, the block folds every byte before the `*` into an 8-bit XOR. It turns the digits after the `*` into a binary value and, in parallel, turns the digits of the sequence field into a binary line number.

When the line-ending byte arrives, the block decides the line's fate. A line whose checksum matches and whose number is the one expected produces a one-cycle acceptance pulse carrying that number. Any failure produces a one-cycle resend pulse carrying the number the block still expects, which is the last accepted number plus one. A line that carries the renumber command `M110` before its `*` restarts the numbering from its own number. Bytes are taken on every cycle that `in_valid` is high, and the block has no stall.

Top module: `lic_line_checker`

## Requirements
- R1: After reset both pulses are low and the expected line number is 1, so a first well-formed line numbered 1 is accepted.
- R2: The checksum is the 8-bit XOR of all bytes of the line from its first byte up to, but excluding, the `*` (0x2A). A line whose decimal checksum equals it and whose number equals the expected number raises `line_ok` with `line_ok_num` set to that number, and the expected number becomes that number plus one, modulo 2^NUM_W.
- R3: A checksum mismatch raises `resend_req` with `resend_num` equal to the expected number, and the expected number is left unchanged.
- R4: A line with a correct checksum but a number other than the expected one raises `resend_req` with the expected number.
- R5: A line with a correct checksum that contains the four bytes `M110` before the `*` is accepted whatever its number, and the expected number becomes its number plus one.
- R6: A line ends at a CR (0x0D) or LF (0x0A) byte. A line-ending byte with no bytes of a line before it (an empty line, or the LF of a CR LF pair) gives no pulse.
- R7: Each of the following is a failure answered by a resend of the expected number: no `*`; a first byte other than `N` (0x4E); no digit right after `N`; no digit after `*`; any non-digit after `*`; a checksum value above 255; a line number above 2^NUM_W−1.
- R8: Each pulse is high for exactly one cycle, the cycle after the line-ending byte is taken, and the two pulses are never high together.
- R9: Every byte with `in_valid` high is consumed, whether lines arrive back to back on consecutive cycles or with idle cycles inside them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | ASCII byte of the stream |
| line_ok | output | 1 | One-cycle acceptance pulse |
| line_ok_num | output | NUM_W | Number of the accepted line, valid with `line_ok` |
| resend_req | output | 1 | One-cycle resend request |
| resend_num | output | NUM_W | Line number asked for again, valid with `resend_req` |

## Verification
The assertions take for granted that `in_byte` is a known value on every cycle in which `in_valid` is high, and that reset is held across at least one rising edge. The bench drives inputs only on falling edges, keeps `in_byte` at a defined ASCII value, and releases reset after several edges. The bench builds each line's checksum from the line text itself, so a correct and a deliberately wrong checksum come from the same rule. Back-to-back line endings, CR LF pairs, idle gaps inside a line and the wrap of the line number past its top value all stay within these assumptions.

// File: rtl/lic_pkg.sv
package lic_pkg;

   localparam logic [7:0] CH_CR   = 8'h0D;
   localparam logic [7:0] CH_LF   = 8'h0A;
   localparam logic [7:0] CH_STAR = 8'h2A;
   localparam logic [7:0] CH_N    = 8'h4E;
   localparam logic [7:0] CH_ZERO = 8'h30;
   localparam logic [7:0] CH_NINE = 8'h39;

   // parser position inside the current line
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // no byte of a line seen yet
      ST_NUM  = 2'd1,   // inside the sequence field after 'N'
      ST_BODY = 2'd2,   // command text before the delimiter
      ST_CK   = 2'd3    // checksum digits after the delimiter
   } lic_state_e;

   function automatic logic is_digit(input logic [7:0] b);
      return (b >= CH_ZERO) && (b <= CH_NINE);
   endfunction

   function automatic logic is_eol(input logic [7:0] b);
      return (b == CH_CR) || (b == CH_LF);
   endfunction

endpackage

// File: rtl/lic_dec_acc.sv
// Decimal digit accumulator with sticky overflow.
module lic_dec_acc #(
   parameter int unsigned     W          = 32,
   parameter bit              FULL_RANGE = 1'b1,
   parameter longint unsigned LIMIT      = 64'd255
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         dig_en,
   input  logic [3:0]   digit,
   output logic [W-1:0] val,
   output logic         seen,
   output logic         ovf
);

   localparam int unsigned XW = W + 4;

   if (W < 4) begin : g_bad_width
      $error("lic_dec_acc: W must be at least 4");
   end

   logic [XW-1:0] nxt;
   logic          hit;

   assign nxt = (XW'(val) * XW'(10)) + XW'(digit);

   // variant: overflow past the register width, or past an explicit limit
   if (FULL_RANGE) begin : g_full
      assign hit = |nxt[XW-1:W];
   end else begin : g_limit
      assign hit = nxt > XW'(LIMIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         val  <= '0;
         seen <= 1'b0;
         ovf  <= 1'b0;
      end else if (dig_en) begin
         seen <= 1'b1;
         if (hit || ovf) begin
            ovf <= 1'b1;
         end else begin
            val <= nxt[W-1:0];
         end
      end
   end

   // R7: no value builds up before the first digit of a field
   p_zero_until_digit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (val == '0) && !ovf);

   // R7: once overflowed, the flag stays until the line is cleared
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

endmodule

// File: rtl/lic_pat_det.sv
// Sticky detector for a fixed byte sequence within the enabled bytes of a line.
module lic_pat_det #(
   parameter int unsigned         LEN = 4,
   parameter logic [8*LEN-1:0]    PAT = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] din,
   output logic       hit
);

   if (LEN < 2) begin : g_bad_len
      $error("lic_pat_det: LEN must be at least 2");
   end

   logic [7:0]     hist_q [LEN-1];
   logic [LEN-1:0] match;

   // the current byte is the last pattern character
   assign match[0] = (din == PAT[7:0]);

   // hist_q[0] is the previous byte, hist_q[i-1] the byte i places back
   for (genvar i = 1; i < LEN; i++) begin : g_cmp
      assign match[i] = (hist_q[i-1] == PAT[8*i +: 8]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int j = 0; j < LEN - 1; j++) hist_q[j] <= 8'h00;
         hit <= 1'b0;
      end else if (en) begin
         hist_q[0] <= din;
         for (int j = 1; j < LEN - 1; j++) hist_q[j] <= hist_q[j-1];
         if (&match) hit <= 1'b1;
      end
   end

   // R5: a found pattern is remembered until the line ends
   p_hit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr) |=> hit);

endmodule

// File: rtl/lic_line_checker.sv
module lic_line_checker
   import lic_pkg::*;
#(
   parameter int unsigned      NUM_W     = 32,
   parameter logic [NUM_W-1:0] FIRST_NUM = NUM_W'(1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             line_ok,
   output logic [NUM_W-1:0] line_ok_num,
   output logic             resend_req,
   output logic [NUM_W-1:0] resend_num
);

   localparam int unsigned         CK_W      = 8;
   localparam longint unsigned     CK_MAX    = (64'd1 << CK_W) - 64'd1;
   localparam int unsigned         PAT_LEN   = 4;
   localparam logic [8*PAT_LEN-1:0] RENUM_PAT = "M110";

   if (NUM_W < 4) begin : g_bad_num_w
      $error("lic_line_checker: NUM_W must be at least 4");
   end

   lic_state_e       st_q, st_d;
   logic             bad_q, bad_d;
   logic [CK_W-1:0]  xor_q;
   logic [NUM_W-1:0] exp_q;

   logic             b_eol, b_dig, b_star;
   logic             clr, body_en, fire, n_dig_en, ck_dig_en;

   logic [NUM_W-1:0] n_val;
   logic             n_seen, n_ovf;
   logic [CK_W-1:0]  ck_val;
   logic             ck_seen, ck_ovf;
   logic             renum;
   logic             ck_ok, take;

   assign b_eol   = is_eol(in_byte);
   assign b_dig   = is_digit(in_byte);
   assign b_star  = (in_byte == CH_STAR);

   assign clr     = in_valid && b_eol;
   assign fire    = in_valid && b_eol && (st_q != ST_IDLE);
   assign body_en = in_valid && !b_eol && !b_star && (st_q != ST_CK);

   // ---------------- line parser ----------------
   always_comb begin
      st_d      = st_q;
      bad_d     = bad_q;
      n_dig_en  = 1'b0;
      ck_dig_en = 1'b0;
      if (in_valid) begin
         if (b_eol) begin
            st_d  = ST_IDLE;
            bad_d = 1'b0;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (in_byte == CH_N) begin
                     st_d = ST_NUM;
                  end else begin
                     st_d  = b_star ? ST_CK : ST_BODY;
                     bad_d = 1'b1;
                  end
               end
               ST_NUM: begin
                  if (b_dig)       n_dig_en = 1'b1;
                  else if (b_star) st_d     = ST_CK;
                  else             st_d     = ST_BODY;
               end
               ST_BODY: begin
                  if (b_star) st_d = ST_CK;
               end
               ST_CK: begin
                  if (b_dig) ck_dig_en = 1'b1;
                  else       bad_d     = 1'b1;
               end
               default: st_d = ST_IDLE;
            endcase
         end
      end
   end

   // ---------------- field accumulators ----------------
   lic_dec_acc #(
      .W          (NUM_W),
      .FULL_RANGE (1'b1),
      .LIMIT      (64'd0)
   ) u_num (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .dig_en (n_dig_en),
      .digit  (in_byte[3:0]),
      .val    (n_val),
      .seen   (n_seen),
      .ovf    (n_ovf)
   );

   lic_dec_acc #(
      .W          (CK_W),
      .FULL_RANGE (1'b0),
      .LIMIT      (CK_MAX)
   ) u_ck (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .dig_en (ck_dig_en),
      .digit  (in_byte[3:0]),
      .val    (ck_val),
      .seen   (ck_seen),
      .ovf    (ck_ovf)
   );

   lic_pat_det #(
      .LEN (PAT_LEN),
      .PAT (RENUM_PAT)
   ) u_renum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (body_en),
      .din   (in_byte),
      .hit   (renum)
   );

   // ---------------- verdict ----------------
   assign ck_ok = (st_q == ST_CK) && !bad_q && ck_seen && !ck_ovf
                  && n_seen && !n_ovf && (ck_val == xor_q);
   assign take  = ck_ok && (renum || (n_val == exp_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         bad_q       <= 1'b0;
         xor_q       <= '0;
         exp_q       <= FIRST_NUM;
         line_ok     <= 1'b0;
         line_ok_num <= '0;
         resend_req  <= 1'b0;
         resend_num  <= '0;
      end else begin
         st_q       <= st_d;
         bad_q      <= bad_d;
         line_ok    <= fire && take;
         resend_req <= fire && !take;
         if (clr) begin
            xor_q <= '0;
         end else if (body_en) begin
            xor_q <= xor_q ^ in_byte;
         end
         if (fire && take) begin
            line_ok_num <= n_val;
            exp_q       <= n_val + NUM_W'(1);
         end
         if (fire && !take) begin
            resend_num <= exp_q;
         end
      end
   end

   // ---------------- assertions ----------------
   p_never_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_ok && resend_req));

   p_ok_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      line_ok |=> !line_ok);

   p_rs_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req |=> !resend_req);

   p_pulse_after_eol_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ok || resend_req) |-> $past(in_valid && is_eol(in_byte)));

   p_next_after_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_ok |-> (exp_q == line_ok_num + NUM_W'(1)));

   p_resend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req |-> (exp_q == $past(exp_q)) && (resend_num == exp_q));

endmodule

// File: tb/lic_line_checker_bench.sv
module lic_line_checker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        line_ok, resend_req;
   logic [31:0] line_ok_num, resend_num;

   always #10 clk = ~clk;   // 50 MHz

   lic_line_checker u_lic_line_checker (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_byte     (in_byte),
      .line_ok     (line_ok),
      .line_ok_num (line_ok_num),
      .resend_req  (resend_req),
      .resend_num  (resend_num)
   );

   int n_chk = 0;
   int n_fail = 0;
   int ok_cnt = 0, rs_cnt = 0, both_cnt = 0;
   int ok0 = 0, rs0 = 0;
   logic [31:0] last_ok = 0, last_rs = 0;
   int cyc = 0;

   // pulse monitor, sampled on falling edges
   always @(negedge clk) begin
      if (rst_n) begin
         if (line_ok)    begin ok_cnt++; last_ok = line_ok_num; end
         if (resend_req) begin rs_cnt++; last_rs = resend_num;  end
         if (line_ok && resend_req) both_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   typedef struct packed {
      logic [8*20-1:0] txt;
      logic            good;
      logic            ack;
      logic [31:0]     num;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{"N1 G28",        1'b1, 1'b1, 32'd1 },  // R2
      '{"N2 G1 X2.0",    1'b0, 1'b0, 32'd2 },  // R3
      '{"N2 G1 X2.0",    1'b1, 1'b1, 32'd2 },  // R2 after R3 kept number
      '{"N5 T0",         1'b1, 1'b0, 32'd3 },  // R4
      '{"N3 G1 F3000.0", 1'b1, 1'b1, 32'd3 },  // R2
      '{"N40 M110",      1'b1, 1'b1, 32'd40},  // R5
      '{"N41 G92 E0",    1'b1, 1'b1, 32'd41},  // R5 follow-on
      '{"G1 X1",         1'b1, 1'b0, 32'd42},  // R7 no N
      '{"N G1",          1'b1, 1'b0, 32'd42},  // R7 no digits
      '{"N42 M110",      1'b0, 1'b0, 32'd42},  // R3 renumber with bad sum
      '{"N42 M110",      1'b1, 1'b1, 32'd42},  // R5
      '{"N0 M110",       1'b1, 1'b1, 32'd0 },  // R5 back to zero
      '{"N1 G4",         1'b1, 1'b1, 32'd1 }   // R2
   };

   function automatic string to_str(input logic [8*20-1:0] t);
      string s = "";
      for (int i = 19; i >= 0; i--) begin
         if (t[8*i +: 8] != 8'h00) s = $sformatf("%s%c", s, t[8*i +: 8]);
      end
      return s;
   endfunction

   function automatic string mk_line(input string body, input bit good, input logic [7:0] term);
      logic [7:0] ck;
      ck = 8'h00;
      for (int i = 0; i < body.len(); i++) ck = ck ^ body[i];
      if (!good) ck = ck + 8'd1;
      return $sformatf("%s*%0d%c", body, ck, term);
   endfunction

   task automatic send(input string s, input bit gap, input bit idle_after);
      for (int i = 0; i < s.len(); i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_byte  = s[i];
         if (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      if (idle_after) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_byte  = 8'h00;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic snap();
      ok0 = ok_cnt;
      rs0 = rs_cnt;
   endtask

   task automatic expect_resp(input int want_ok, input int want_rs,
                              input logic [31:0] want_num, input string tag);
      int d_ok, d_rs;
      logic [31:0] got;
      d_ok = ok_cnt - ok0;
      d_rs = rs_cnt - rs0;
      got  = (want_ok != 0) ? last_ok : last_rs;
      n_chk++;
      if (d_ok != want_ok || d_rs != want_rs || both_cnt != 0 ||
          ((want_ok != 0 || want_rs != 0) && got != want_num)) begin
         n_fail++;
         $display("FAIL %s: ok=%0d resend=%0d both=%0d num=%0d, expected ok=%0d resend=%0d both=0 num=%0d",
                  tag, d_ok, d_rs, both_cnt, got, want_ok, want_rs, want_num);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();

      // R1: outputs idle after reset
      n_chk++;
      if (line_ok !== 1'b0 || resend_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset state: ok=%b resend=%b, expected 0 0", line_ok, resend_req);
      end

      // table walk: R2 R3 R4 R5 R7 (first row also shows R1 start at 1)
      for (int k = 0; k < NV; k++) begin
         snap();
         send(mk_line(to_str(VECS[k].txt), VECS[k].good, 8'h0A), 1'b0, 1'b1);
         expect_resp(VECS[k].ack ? 1 : 0, VECS[k].ack ? 0 : 1, VECS[k].num,
                     $sformatf("table row %0d (R2/R3/R4/R5/R7)", k));
      end

      // R7: no delimiter
      snap(); send("N2 G1 X5\n", 1'b0, 1'b1);
      expect_resp(0, 1, 32'd2, "R7 no delimiter");

      // R7: checksum value above 255
      snap(); send("N2 G1*300\n", 1'b0, 1'b1);
      expect_resp(0, 1, 32'd2, "R7 checksum over 255");

      // R7: no digits after delimiter
      snap(); send("N2 G1*\n", 1'b0, 1'b1);
      expect_resp(0, 1, 32'd2, "R7 empty checksum");

      // R7: non-digit after delimiter (correct sum followed by a letter)
      snap(); send({mk_line("N2 G1", 1'b1, 8'h61), "\n"}, 1'b0, 1'b1);
      expect_resp(0, 1, 32'd2, "R7 letter in checksum");

      // R6: empty lines and lone line endings give nothing
      snap(); send("\r\n\n\r", 1'b0, 1'b1);
      expect_resp(0, 0, 32'd0, "R6 empty lines");

      // R6: CR ends a line, trailing LF of the pair is silent
      snap(); send(mk_line("N2 G0 Y1", 1'b1, 8'h0D), 1'b0, 1'b1);
      expect_resp(1, 0, 32'd2, "R6 CR terminator");
      snap(); send("\n", 1'b0, 1'b1);
      expect_resp(0, 0, 32'd0, "R6 LF after CR");

      // R9: idle cycles inside a line
      snap(); send(mk_line("N3 G1 Y2", 1'b1, 8'h0A), 1'b1, 1'b1);
      expect_resp(1, 0, 32'd3, "R9 gapped bytes");

      // R9 and R8: two lines with no idle cycle between them
      snap();
      send(mk_line("N4 G1 X7", 1'b1, 8'h0A), 1'b0, 1'b0);
      send(mk_line("N5 G1 X8", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(2, 0, 32'd5, "R9 back-to-back lines");

      // R7: line number beyond 32 bits
      snap(); send(mk_line("N4294967296 M110", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(0, 1, 32'd6, "R7 number overflow");

      // R5 at the top number, then R2 wrap to zero
      snap(); send(mk_line("N4294967295 M110", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(1, 0, 32'hFFFF_FFFF, "R5 top number");
      snap(); send(mk_line("N0 G1", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(1, 0, 32'd0, "R2 wrap to zero");

      // R4: stale number after the wrap
      snap(); send(mk_line("N0 G1", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(0, 1, 32'd1, "R4 repeated number");

      // R1: reset mid-stream restores the start number
      snap(); send(mk_line("N1 G1", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(1, 0, 32'd1, "R2 before reset");
      do_reset();
      snap(); send(mk_line("N1 G2", 1'b1, 8'h0A), 1'b0, 1'b1);
      expect_resp(1, 0, 32'd1, "R1 after reset");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule